// File: doc/BRIEF.md
# Bordered Raster Timing Generator

This block produces the line and field timing for a raster display whose visible area is a programmable border rectangle with a smaller display window inside it. A horizontal counter runs over a programmable number of pixel clocks per line. A vertical counter runs over a programmable number of lines per field. From these two counters the block derives the sync pulses, a border-active flag and a window-active flag. It also gives the pixel coordinates inside the window to the pixel fetcher. The colour output carries the fetched pixel inside the window, a programmable border colour in the rest of the border rectangle, and black elsewhere.

Software programs the block through a simple write port. Every write lands in a shadow copy. The whole shadow set is copied to the active set in one step, on the clock edge where one field ends and the next begins (the vertical retrace). The same edge raises an interrupt flag, which software clears by writing to a dedicated address. The block also supports interlaced output with a separate window start line per field, horizontal pixel doubling, scan doubling, and a blank control that turns the whole border rectangle into border colour.

Top module: `bordered_raster_timing`

## Requirements
- R1: After reset the video enable is off, so hsync, vsync, border_active, window_active, color_out and irq are all 0.
- R2: A line lasts htot clocks and a progressive field lasts vtot lines. Both totals come from address 0: htot in bits [15:0] and vtot in bits [31:16]. Consecutive retrace edges are therefore htot*vtot clocks apart.
- R3: While video is enabled, hsync is high for the first HS_LEN clocks of every line and vsync is high for the first VS_LEN lines of every field. Counting starts at 0.
- R4: border_active is high when h lies in [start, stop) of address 1 (start in [31:16], stop in [15:0]) and v lies in the matching range of address 2. In the border outside the window, color_out is the border colour from address 9 bits [23:0]. Outside the border, color_out is 0.
- R5: window_active is high inside the border when h is in [hs, hs+width) and v is in [vs, vs+height). hs comes from address 3 bits [15:0]. Address 4 holds width in [15:0] and height in [31:16]. Inside the window, color_out equals pix_data and win_x/win_y give the offset from the window corner.
- R6: Setting bit 3 of address 6 (blank) forces window_active low, so the whole border rectangle shows the border colour.
- R7: Writes to addresses 0 to 9 take effect only from the first clock of the next field. The retrace edge sets irq. A write with bit 0 set to address 10 clears irq.
- R8: Bit 4 of address 8 selects interlace. The field output then toggles at each retrace, starting from 0. Field 0 uses the window start line in address 5 bits [31:16] and lasts vtot lines. Field 1 uses bits [15:0] and lasts vtot+1 lines.
- R9: Bit 0 of address 6 halves win_x (pixel doubling). Bit 1 of address 7 halves win_y (scan doubling).
- R10: Bit 8 of address 8 is the video enable; when it is 0, every timing and colour output is 0. Bit 0 of address 7 is the display enable; when it is 0, the window is off but the border is still shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | 32 | Register write data |
| pix_data | input | CDW | Pixel colour from the fetcher |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| field | output | 1 | Current interlaced field |
| border_active | output | 1 | Inside the border rectangle |
| window_active | output | 1 | Inside the display window |
| color_out | output | CDW | Output colour |
| win_x | output | CW | Horizontal pixel index inside the window |
| win_y | output | CW | Vertical line index inside the window |
| irq | output | 1 | Retrace interrupt flag |

## Verification
The hardest case to reach is the interlaced pair of fields. Field 1 runs one line longer and uses a different window start row. It only becomes visible two retraces after interlace is switched on, and only after the switch itself has been committed at a retrace. The bench reaches it by enabling interlace in the shadow set and then stepping through three retrace edges. It measures each field length in clocks and probes the window edge rows in each field. Shadowing is exposed by changing the border colour mid-field and sampling that colour both before and after the next retrace.

// File: rtl/bordered_raster_timing.sv
module bordered_raster_timing #(
  parameter int CW       = 12,
  parameter int CDW      = 24,
  parameter int AW       = 4,
  parameter int HS_LEN   = 8,
  parameter int VS_LEN   = 3,
  parameter int RST_HTOT = 857,
  parameter int RST_VTOT = 262
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [CDW-1:0] pix_data,
  output logic           hsync,
  output logic           vsync,
  output logic           field,
  output logic           border_active,
  output logic           window_active,
  output logic [CDW-1:0] color_out,
  output logic [CW-1:0]  win_x,
  output logic [CW-1:0]  win_y,
  output logic           irq
);
  localparam int NREG = 10;
  localparam int A_TOT = 0, A_HB = 1, A_VB = 2, A_WH = 3, A_WS = 4;
  localparam int A_WV = 5, A_CFG = 6, A_MODE = 7, A_SYNC = 8, A_BCOL = 9;
  localparam logic [AW-1:0] A_IRQ = AW'(10);

  logic [31:0]   shd [NREG];
  logic [31:0]   act [NREG];
  logic [CW-1:0] h, v;
  logic          fld;

  wire [CW-1:0]  htot  = act[A_TOT][CW-1:0];
  wire [CW-1:0]  vtot  = act[A_TOT][16 +: CW];
  wire           il    = act[A_SYNC][4];
  wire           ven   = act[A_SYNC][8];
  wire           den   = act[A_MODE][0];
  wire           sdbl  = act[A_MODE][1];
  wire           pdbl  = act[A_CFG][0];
  wire           blank = act[A_CFG][3];
  wire           fsel  = il & fld;
  wire [CW-1:0]  vlast = vtot + {{(CW-1){1'b0}}, fsel} - CW'(1);
  wire           line_end = (h == htot - CW'(1));
  wire           commit   = line_end && (v == vlast);

  wire [CW-1:0]  hbs = act[A_HB][16 +: CW];
  wire [CW-1:0]  hbe = act[A_HB][CW-1:0];
  wire [CW-1:0]  vbs = act[A_VB][16 +: CW];
  wire [CW-1:0]  vbe = act[A_VB][CW-1:0];
  wire [CW-1:0]  whs = act[A_WH][CW-1:0];
  wire [CW-1:0]  ww  = act[A_WS][CW-1:0];
  wire [CW-1:0]  wh  = act[A_WS][16 +: CW];
  wire [CW-1:0]  wvs = fsel ? act[A_WV][CW-1:0] : act[A_WV][16 +: CW];
  wire [CDW-1:0] bcol = act[A_BCOL][CDW-1:0];
  wire [CW-1:0]  hx = h - whs;
  wire [CW-1:0]  vy = v - wvs;

  logic unused_bits;
  assign unused_bits = ^{act[0], act[1], act[2], act[3], act[4],
                         act[5], act[6], act[7], act[8], act[9]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        shd[i] <= '0;
        act[i] <= '0;
      end
      shd[A_TOT] <= {16'(RST_VTOT), 16'(RST_HTOT)};
      act[A_TOT] <= {16'(RST_VTOT), 16'(RST_HTOT)};
    end else begin
      if (wr_en && (wr_addr < AW'(NREG)))
        shd[wr_addr] <= wr_data;
      if (commit)
        for (int i = 0; i < NREG; i++) act[i] <= shd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h   <= '0;
      v   <= '0;
      fld <= 1'b0;
    end else if (line_end) begin
      h <= '0;
      if (v == vlast) begin
        v   <= '0;
        fld <= il ? ~fld : 1'b0;
      end else begin
        v <= v + CW'(1);
      end
    end else begin
      h <= h + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq <= 1'b0;
    else if (commit)
      irq <= 1'b1;
    else if (wr_en && wr_addr == A_IRQ && wr_data[0])
      irq <= 1'b0;
  end

  wire in_b = ven && (h >= hbs) && (h < hbe) && (v >= vbs) && (v < vbe);
  wire in_w = in_b && den && !blank && (h >= whs) && (hx < ww) &&
              (v >= wvs) && (vy < wh);

  assign hsync         = ven && (h < CW'(HS_LEN));
  assign vsync         = ven && (v < CW'(VS_LEN));
  assign field         = fsel;
  assign border_active = in_b;
  assign window_active = in_w;
  assign color_out     = in_w ? pix_data : (in_b ? bcol : '0);
  assign win_x         = in_w ? (pdbl ? (hx >> 1) : hx) : '0;
  assign win_y         = in_w ? (sdbl ? (vy >> 1) : vy) : '0;

  AST_H_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (htot != '0) |-> (h < htot)); // R2
  AST_VSYNC_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (h == '0)); // R3
  AST_IRQ_AT_RETRACE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act[A_BCOL])); // R7
  AST_FIELD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && il) |=> (fld != $past(fld))); // R8
endmodule

// File: tb/sim_bordered_raster_timing.sv
module sim_bordered_raster_timing;
  localparam int CW = 12, CDW = 24, AW = 4;
  localparam int HT = 48, VT = 24;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [CDW-1:0] pix_data = 24'h123456;
  logic hsync, vsync, field, border_active, window_active, irq;
  logic [CDW-1:0] color_out;
  logic [CW-1:0] win_x, win_y;

  int errors = 0, checks = 0, cur = 0, flen = 0;
  logic s_hs, s_vs, s_fld, s_b;

  always #2 clk = ~clk;

  bordered_raster_timing #(.CW(CW), .CDW(CDW), .AW(AW), .HS_LEN(8), .VS_LEN(3),
    .RST_HTOT(HT), .RST_VTOT(VT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_data(pix_data), .hsync(hsync), .vsync(vsync), .field(field),
    .border_active(border_active), .window_active(window_active),
    .color_out(color_out), .win_x(win_x), .win_y(win_y), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cur++;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic seek(input int x, input int y);
    int tgt = y * HT + x;
    if (tgt < cur) chk("seek order", 32'(cur), 32'(tgt));
    while (cur < tgt) tick();
  endtask

  task automatic wait_sync();
    int n = 0;
    wr(10, 1);
    chk("R7 irq cleared", 32'(irq), 0);
    while (!irq && n < 5000) begin tick(); n++; end
    if (n >= 5000) chk("watchdog retrace", 0, 1);
    flen = cur; cur = 0;
    s_hs = hsync; s_vs = vsync; s_fld = field; s_b = border_active;
  endtask

  task automatic t_reset();
    chk("R1 hsync", 32'(hsync), 0);
    chk("R1 vsync", 32'(vsync), 0);
    chk("R1 border", 32'(border_active), 0);
    chk("R1 window", 32'(window_active), 0);
    chk("R1 color", 32'(color_out), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_geometry();
    chk("R3 hsync at line start", 32'(s_hs), 1);
    chk("R3 vsync at field start", 32'(s_vs), 1);
    chk("R4 no border at origin", 32'(s_b), 0);
    seek(8, 0);  chk("R3 hsync end", 32'(hsync), 0);
    seek(20, 2); chk("R3 vsync last line", 32'(vsync), 1);
    seek(20, 3); chk("R3 vsync end", 32'(vsync), 0);
    seek(9, 5);  chk("R4 left of border", 32'(border_active), 0);
    chk("R4 black outside", 32'(color_out), 0);
    seek(12, 5); chk("R4 border on", 32'(border_active), 1);
    chk("R4 border colour", 32'(color_out), 32'h00AA55);
    chk("R4 window off", 32'(window_active), 0);
    seek(44, 5); chk("R4 border stop exclusive", 32'(border_active), 0);
    seek(16, 8); chk("R5 window corner", 32'(window_active), 1);
    chk("R5 pixel passthrough", 32'(color_out), 32'h123456);
    chk("R5 win_x corner", 32'(win_x), 0);
    seek(21, 10); chk("R9 win_x undoubled", 32'(win_x), 5);
    chk("R9 win_y undoubled", 32'(win_y), 2);
    seek(32, 10); chk("R5 window right edge", 32'(window_active), 0);
    chk("R5 border right of window", 32'(border_active), 1);
    seek(16, 16); chk("R5 window bottom edge", 32'(window_active), 0);
    wait_sync();
    chk("R2 field length", 32'(flen), 32'(HT * VT));
  endtask

  task automatic t_shadow();
    seek(0, 2);
    wr(9, 32'h0000FF);
    seek(12, 5); chk("R7 colour held until retrace", 32'(color_out), 32'h00AA55);
    wait_sync();
    chk("R7 irq at retrace", 32'(irq), 1);
    seek(12, 5); chk("R7 colour applied after retrace", 32'(color_out), 32'h0000FF);
  endtask

  task automatic t_blank();
    wr(6, 32'h8);
    wait_sync();
    seek(16, 8); chk("R6 window suppressed", 32'(window_active), 0);
    chk("R6 border kept", 32'(border_active), 1);
    seek(21, 10); chk("R6 border colour in window", 32'(color_out), 32'h0000FF);
    wr(6, 0);
  endtask

  task automatic t_double();
    wr(6, 1);
    wr(7, 3);
    wait_sync();
    seek(16, 8); chk("R9 window on", 32'(window_active), 1);
    seek(21, 11); chk("R9 win_x halved", 32'(win_x), 2);
    chk("R9 win_y halved", 32'(win_y), 1);
    wr(6, 0);
    wr(7, 1);
  endtask

  task automatic t_interlace();
    wr(8, 32'h110);
    wait_sync();
    chk("R8 first field is 0", 32'(s_fld), 0);
    seek(16, 7); chk("R8 field0 above start", 32'(window_active), 0);
    seek(16, 8); chk("R8 field0 start row", 32'(window_active), 1);
    wait_sync();
    chk("R8 field0 length", 32'(flen), 32'(HT * VT));
    chk("R8 field toggles to 1", 32'(s_fld), 1);
    seek(16, 8); chk("R8 field1 above start", 32'(window_active), 0);
    seek(16, 9); chk("R8 field1 start row", 32'(window_active), 1);
    wait_sync();
    chk("R8 field1 one line longer", 32'(flen), 32'(HT * (VT + 1)));
    chk("R8 field back to 0", 32'(s_fld), 0);
    wr(8, 32'h100);
    wait_sync();
  endtask

  task automatic t_disable();
    wr(7, 0);
    wait_sync();
    seek(16, 9); chk("R10 display off: no window", 32'(window_active), 0);
    chk("R10 display off: border", 32'(border_active), 1);
    chk("R10 display off: colour", 32'(color_out), 32'h0000FF);
    wr(8, 0);
    wait_sync();
    chk("R10 video off: hsync", 32'(s_hs), 0);
    chk("R10 video off: vsync", 32'(s_vs), 0);
    seek(12, 5); chk("R10 video off: border", 32'(border_active), 0);
    chk("R10 video off: colour", 32'(color_out), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    wr(0, {16'(VT), 16'(HT)});
    wr(1, {16'd10, 16'd44});
    wr(2, {16'd4, 16'd22});
    wr(3, 32'd16);
    wr(4, {16'd8, 16'd16});
    wr(5, {16'd8, 16'd9});
    wr(6, 0);
    wr(7, 1);
    wr(8, 32'h100);
    wr(9, 32'h00AA55);
    wait_sync();
    t_geometry();
    t_shadow();
    t_blank();
    t_double();
    t_interlace();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule